// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block moves outgoing packets from system memory to a byte stream. Software builds a chain of four-word descriptors in memory. It writes the address of the first one into the ring-base register, then sets the enable and kick bits together in a single control write. The engine then walks the chain through a simple word-wide memory port. For each descriptor it reads the ownership word, the control word, the buffer pointer and the link word, in that order. Where the engine owns the descriptor, it reads the buffer bytes into an internal byte buffer. It then writes the ownership word back with the owner bit cleared and moves on to the next descriptor.

The byte stream uses a valid/ready handshake and carries start-of-frame, end-of-frame and error markers. One frame may span several descriptors. It closes at the descriptor whose control word carries the last mark. In buffered mode, no byte of a frame leaves until the whole frame is held internally. In pass-through mode, bytes leave as soon as they arrive, except that the final byte waits until the frame is closed. The engine stops at the first descriptor it does not own. It keeps that descriptor's address, so that a later kick resumes from that point.

Top module: `txd_chain_dma`

## Requirements
- R1: After reset, `busy`, `tx_valid` and `mem_req` are low, and the current-descriptor register (register 2) reads 0.
- R2: A write to control register 1 with bit 31 (kick) set starts the engine only if bit 30 (enable) is set in the same write. A kick without enable causes no memory access and leaves `busy` low.
- R3: A descriptor at address A is read as four words, in this order: ownership word at A, control word at A+4, buffer byte address at A+8 and link word at A+12. Bit 31 of the ownership word grants the descriptor to the engine. In the control word, bits 13:0 hold the byte length, bit 30 marks the last descriptor of a frame and bit 24 selects linked mode. All memory accesses are word aligned.
- R4: Buffer bytes leave in address order, starting at any byte offset. Byte k of a memory word is bits 8k+7:8k. Exactly the programmed length is sent from each descriptor.
- R5: `tx_first` marks the first byte after the end of the previous frame. `tx_last` marks the final byte of the descriptor that carries the last mark. Descriptors in between form one frame.
- R6: When the engine finishes a descriptor, it writes the ownership word back with bit 31 cleared and all other bits unchanged.
- R7: With bit 24 set, the next descriptor is at the address held in the link word. With bit 24 clear, the next descriptor is at the current address plus 16.
- R8: When the engine reads an ownership word with bit 31 clear, it stops: `busy` falls and register 2 holds that descriptor's address. A later kick restarts the engine at that address.
- R9: With control bit 1 set (buffered mode), `tx_valid` does not rise for a frame until the ownership write-back of its last descriptor has happened. With bit 1 clear, the first byte of a long frame is offered before that write-back.
- R10: A frame longer than 2048 bytes is cut to its first 2048 bytes. `tx_err` is raised together with `tx_last` on the final byte that is sent.
- R11: A frame with a total length of zero sends no bytes, but its descriptor is still handed back as in R6.
- R12: A write to the ring base (register 0) while `busy` is high is ignored. A write while idle sets both the base and the current-descriptor register.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index: 0 base, 1 control, 2 current descriptor |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write (ownership write-back) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completion; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of frame |
| tx_last | output | 1 | Final byte of frame |
| tx_err | output | 1 | Frame was truncated (with `tx_last`) |
| busy | output | 1 | Engine is walking the chain |

## Verification
The hardest behaviour to bring out at the ports is the timing split between the two modes. In buffered mode the first byte may not appear before the last descriptor is handed back; in pass-through mode it must appear before that. The bench checks this on the first cycle that `tx_valid` is high by reading the ownership bit in its own memory model. A 200-byte frame gives a wide enough window. A 2100-byte frame fills the internal buffer exactly and then forces bytes to be dropped. A descriptor that is not owned stops the engine partway through a walk, and the test then resumes from that point with a chain that is unaligned and not linked, under backpressure.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int OWN_BIT   = 31;
  localparam int LAST_BIT  = 30;
  localparam int CHAIN_BIT = 24;

  typedef enum logic [3:0] {
    W_IDLE, W_WAIT_OUT, W_STAT, W_CTRL, W_BUF, W_NEXT, W_WORD, W_PUSH, W_RELEASE
  } walk_st_e;

  function automatic logic [31:0] align4(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] follow_link(input logic [31:0] cur,
                                              input logic chain,
                                              input logic [31:0] link);
    return chain ? align4(link) : cur + 32'd16;
  endfunction

  function automatic logic [31:0] owner_released(input logic [31:0] s);
    return s & ~(32'h1 << OWN_BIT);
  endfunction

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/txd_byte_fifo.sv
module txd_byte_fifo #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  output logic [7:0]    rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [7:0]    store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = store[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/txd_desc_walker.sv
module txd_desc_walker
  import txd_pkg::*;
#(
  parameter int MAX_FRAME = 2048,
  parameter int LEN_W     = 14,
  localparam int FB_W     = $clog2(MAX_FRAME) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        kick,
  input  logic        cur_load,
  input  logic [31:0] cur_load_val,
  input  logic        out_idle,
  input  logic        fifo_full,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        byte_push,
  output logic [7:0]  byte_data,
  output logic        frame_end,
  output logic        frame_trunc,
  output logic        busy,
  output logic [31:0] cur_desc
);
  walk_st_e          st;
  logic [31:0]       cur, stat_q, bufp, link_q, word_q;
  logic [LEN_W-1:0]  len_q, remain;
  logic              last_q, chain_q, in_frame, trunc_q;
  logic [FB_W-1:0]   fbytes;
  logic              keep, byte_step;

  assign keep      = fbytes < FB_W'(MAX_FRAME);
  assign byte_step = (st == W_PUSH) && (!keep || !fifo_full);
  assign byte_push = (st == W_PUSH) && keep && !fifo_full;
  assign byte_data = lane_byte(word_q, bufp[1:0]);
  assign frame_end = (st == W_RELEASE) && mem_ack && last_q;
  assign frame_trunc = trunc_q;
  assign busy      = (st != W_IDLE);
  assign cur_desc  = cur;
  assign mem_wdata = owner_released(stat_q);

  always_comb begin
    mem_req  = 1'b1;
    mem_we   = 1'b0;
    mem_addr = cur;
    case (st)
      W_STAT:    mem_addr = cur;
      W_CTRL:    mem_addr = cur + 32'd4;
      W_BUF:     mem_addr = cur + 32'd8;
      W_NEXT:    mem_addr = cur + 32'd12;
      W_WORD:    mem_addr = align4(bufp);
      W_RELEASE: mem_we   = 1'b1;
      default:   mem_req  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      cur      <= '0;
      stat_q   <= '0;
      bufp     <= '0;
      link_q   <= '0;
      word_q   <= '0;
      len_q    <= '0;
      remain   <= '0;
      last_q   <= 1'b0;
      chain_q  <= 1'b0;
      in_frame <= 1'b0;
      trunc_q  <= 1'b0;
      fbytes   <= '0;
    end else begin
      case (st)
        W_IDLE: begin
          if (cur_load) cur <= align4(cur_load_val);
          if (kick) st <= W_WAIT_OUT;
        end
        W_WAIT_OUT: if (in_frame || out_idle) st <= W_STAT;
        W_STAT: if (mem_ack) begin
          if (mem_rdata[OWN_BIT]) begin
            stat_q <= mem_rdata;
            st     <= W_CTRL;
          end else begin
            st <= W_IDLE;
          end
        end
        W_CTRL: if (mem_ack) begin
          len_q   <= mem_rdata[LEN_W-1:0];
          last_q  <= mem_rdata[LAST_BIT];
          chain_q <= mem_rdata[CHAIN_BIT];
          if (!in_frame) begin
            in_frame <= 1'b1;
            fbytes   <= '0;
            trunc_q  <= 1'b0;
          end
          st <= W_BUF;
        end
        W_BUF: if (mem_ack) begin
          bufp <= mem_rdata;
          st   <= W_NEXT;
        end
        W_NEXT: if (mem_ack) begin
          link_q <= mem_rdata;
          remain <= len_q;
          st     <= (len_q == '0) ? W_RELEASE : W_WORD;
        end
        W_WORD: if (mem_ack) begin
          word_q <= mem_rdata;
          st     <= W_PUSH;
        end
        W_PUSH: if (byte_step) begin
          bufp   <= bufp + 32'd1;
          remain <= remain - 1'b1;
          if (keep) fbytes <= fbytes + 1'b1;
          else      trunc_q <= 1'b1;
          if (remain == LEN_W'(1))      st <= W_RELEASE;
          else if (bufp[1:0] == 2'b11)  st <= W_WORD;
        end
        W_RELEASE: if (mem_ack) begin
          cur <= follow_link(cur, chain_q, link_q);
          if (last_q) in_frame <= 1'b0;
          st <= W_WAIT_OUT;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_frame_out.sv
module txd_frame_out #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sf_mode,
  input  logic          frame_end,
  input  logic          frame_trunc,
  input  logic          fifo_empty,
  input  logic [CW-1:0] fifo_cnt,
  input  logic [7:0]    fifo_rdata,
  input  logic          tx_ready,
  output logic          pop,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_first,
  output logic          tx_last,
  output logic          tx_err,
  output logic          out_idle
);
  logic frame_done, err_q, first_pend, avail;

  assign avail    = frame_done || (!sf_mode && fifo_cnt > CW'(1));
  assign tx_valid = !fifo_empty && avail;
  assign tx_data  = fifo_rdata;
  assign tx_last  = frame_done && (fifo_cnt == CW'(1));
  assign tx_err   = tx_last && err_q;
  assign tx_first = first_pend;
  assign pop      = tx_valid && tx_ready;
  assign out_idle = fifo_empty && !frame_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      err_q      <= 1'b0;
      first_pend <= 1'b1;
    end else begin
      if (frame_end) begin
        frame_done <= 1'b1;
        err_q      <= frame_trunc;
      end else if ((pop && tx_last) || (frame_done && fifo_empty)) begin
        frame_done <= 1'b0;
      end
      if (pop) first_pend <= tx_last;
    end
  end
endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma #(
  parameter int BUF_BYTES = 2048,
  parameter int LEN_W     = 14,
  localparam int CW       = $clog2(BUF_BYTES) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_first,
  output logic        tx_last,
  output logic        tx_err,
  output logic        busy
);
  logic [31:0]   base_q, cur_desc;
  logic          en_q, sf_q, kick, cur_load;
  logic          out_idle, fifo_full, fifo_empty, byte_push, pop;
  logic          frame_end, frame_trunc;
  logic [7:0]    byte_data, fifo_rdata;
  logic [CW-1:0] fifo_cnt;

  assign kick     = cfg_we && (cfg_addr == 2'd1) && cfg_wdata[31] && cfg_wdata[30];
  assign cur_load = cfg_we && (cfg_addr == 2'd0) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      sf_q   <= 1'b0;
    end else begin
      if (cur_load) base_q <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd1) begin
        en_q <= cfg_wdata[30];
        sf_q <= cfg_wdata[1];
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = base_q;
      2'd1:    cfg_rdata = {1'b0, en_q, 28'd0, sf_q, 1'b0};
      2'd2:    cfg_rdata = cur_desc;
      default: cfg_rdata = '0;
    endcase
  end

  txd_desc_walker #(.MAX_FRAME(BUF_BYTES), .LEN_W(LEN_W)) i_walker (
    .clk(clk), .rst_n(rst_n), .kick(kick), .cur_load(cur_load),
    .cur_load_val(cfg_wdata), .out_idle(out_idle), .fifo_full(fifo_full),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .byte_push(byte_push),
    .byte_data(byte_data), .frame_end(frame_end), .frame_trunc(frame_trunc),
    .busy(busy), .cur_desc(cur_desc)
  );

  txd_byte_fifo #(.DEPTH(BUF_BYTES)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(byte_push), .wdata(byte_data), .pop(pop),
    .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
  );

  txd_frame_out #(.CW(CW)) i_out (
    .clk(clk), .rst_n(rst_n), .sf_mode(sf_q), .frame_end(frame_end),
    .frame_trunc(frame_trunc), .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt),
    .fifo_rdata(fifo_rdata), .tx_ready(tx_ready), .pop(pop), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last), .tx_err(tx_err),
    .out_idle(out_idle)
  );
endmodule

// File: rtl/txd_chain_dma_chk.sv
module txd_chain_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_err,
  input logic        busy,
  input logic        byte_push,
  input logic        fifo_full
);
  a_r6_release_clears_owner: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  a_r10_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> tx_last);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    byte_push |-> !fifo_full);
  a_r13_hold_stream: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !cfg_we |=> tx_valid && $stable(tx_data));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind txd_chain_dma txd_chain_dma_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_err(tx_err),
  .busy(busy), .byte_push(byte_push), .fifo_full(fifo_full)
);

// File: tb/test_txd_chain_dma.sv
module test_txd_chain_dma;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int CAP        = 2048;

  typedef struct { logic [7:0] d; logic f; logic l; logic e; } beat_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0, tx_valid, tx_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0]  tx_data;
  logic        tx_first, tx_last, tx_err, busy;

  logic [31:0] mem [0:16383];
  beat_t       exp_q[$];
  int          checks = 0, errors = 0, cyc = 0, mem_acc = 0;
  int          exp_total = 0;
  bit          bp_en = 1'b0, watch_on = 1'b0, watch_owner = 1'b0;
  int          watch_addr = 0;
  string       tag = "R4";
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_chain_dma i_txd_chain_dma (.*);

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_acc <= mem_acc + 1;
      if (mem_we) mem[mem_addr >> 2] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr >> 2];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: scoreboard pop, backpressure, watchdog
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) tx_ready = 1'b0;
    else        tx_ready = !bp_en || (cyc % 3 != 0);
    if (rst_n && tx_valid && watch_on) begin
      chk(mem[watch_addr >> 2][31] == watch_owner, "R9 owner bit at first byte",
          32'(mem[watch_addr >> 2][31]), 32'(watch_owner));
      watch_on = 1'b0;
    end
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {tag, " unexpected byte"}, 32'(tx_data), 32'hx);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk({tx_err, tx_first, tx_last, tx_data} == {e.e, e.f, e.l, e.d},
            {tag, " beat {err,first,last,data}"},
            32'({tx_err, tx_first, tx_last, tx_data}), 32'({e.e, e.f, e.l, e.d}));
      end
    end
    if (cyc > WATCHDOG) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'(WATCHDOG));
      finish_run();
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic put_byte(input int a, input logic [7:0] b);
    mem[a >> 2][(a % 4) * 8 +: 8] = b;
  endtask

  // driver: builds a descriptor and its buffer, queues the expected bytes
  task automatic make_desc(input int da, input logic [31:0] status, input int ba, input int len,
                           input bit lst, input bit chain, input int nxt, input int seed);
    mem[da >> 2]       = status;
    mem[(da >> 2) + 1] = (32'(lst) << 30) | (32'h1 << 29) | (32'(chain) << 24) | 32'(len);
    mem[(da >> 2) + 2] = 32'(ba);
    mem[(da >> 2) + 3] = 32'(nxt);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(seed + i * 7);
      put_byte(ba + i, b);
      if (status[31]) begin
        if (exp_total < CAP) exp_q.push_back('{b, exp_total == 0, 1'b0, 1'b0});
        exp_total++;
      end
    end
    if (status[31] && lst) begin
      if (exp_total > 0) begin
        exp_q[exp_q.size() - 1].l = 1'b1;
        exp_q[exp_q.size() - 1].e = (exp_total > CAP);
      end
      exp_total = 0;
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (n < 20000 && (busy || tx_valid || exp_q.size() != 0));
    chk(n < 20000, {req, " run completes"}, 32'(n), 32'd20000);
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !tx_valid && !mem_req, "R1 outputs idle", {busy, tx_valid, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_read(2'd2, rv);
    chk(rv == 0, "R1 current descriptor", rv, 0);

    // R2: kick without enable
    cfg_write(2'd1, 32'h8000_0000);
    repeat (10) @(negedge clk);
    chk(!busy && mem_acc == 0, "R2 kick needs enable", {busy, 31'(mem_acc)}, 0);

    // R3 R6 R7 R9: single linked descriptor, buffered mode
    tag = "R3";
    make_desc(32'h100, 32'h8000_00A5, 32'h1000, 13, 1'b1, 1'b1, 32'h300, 11);
    mem[32'h300 >> 2] = 32'h0;
    cfg_write(2'd0, 32'h100);
    watch_addr = 32'h100; watch_owner = 1'b0; watch_on = 1'b1;
    cfg_write(2'd1, 32'hC000_0002);
    wait_done("R3");
    chk(mem[32'h100 >> 2] == 32'h0000_00A5, "R6 owner cleared, rest kept", mem[32'h100 >> 2], 32'hA5);
    cfg_read(2'd2, rv);
    chk(rv == 32'h300, "R7 linked next / R8 stop address", rv, 32'h300);
    chk(!watch_on, "R9 buffered watch fired", 32'(watch_on), 0);

    // R8 resume, R4 unaligned, R5 two-descriptor frame, R7 contiguous next, R13 backpressure
    tag = "R5";
    bp_en = 1'b1;
    make_desc(32'h300, 32'h8000_0000, 32'h2003, 5, 1'b0, 1'b0, 32'h0, 40);
    make_desc(32'h310, 32'h8000_0000, 32'h2101, 9, 1'b1, 1'b1, 32'h400, 90);
    mem[32'h400 >> 2] = 32'h0;
    cfg_write(2'd1, 32'hC000_0000);
    wait_done("R8");
    cfg_read(2'd2, rv);
    chk(rv == 32'h400, "R7 contiguous then linked", rv, 32'h400);
    chk(mem[32'h310 >> 2][31] == 1'b0, "R6 second descriptor released", mem[32'h310 >> 2], 0);
    bp_en = 1'b0;

    // R9: pass-through sends before write-back
    tag = "R9";
    make_desc(32'h400, 32'h8000_0000, 32'h3000, 200, 1'b1, 1'b1, 32'h500, 3);
    mem[32'h500 >> 2] = 32'h0;
    watch_addr = 32'h400; watch_owner = 1'b1; watch_on = 1'b1;
    cfg_write(2'd1, 32'hC000_0000);
    wait_done("R9");

    // R11: zero-length frame then a short frame
    tag = "R11";
    make_desc(32'h500, 32'h8000_0000, 32'h3800, 0, 1'b1, 1'b1, 32'h510, 0);
    make_desc(32'h510, 32'h8000_0000, 32'h3900, 4, 1'b1, 1'b1, 32'h520, 77);
    mem[32'h520 >> 2] = 32'h0;
    cfg_write(2'd1, 32'hC000_0002);
    wait_done("R11");
    chk(mem[32'h500 >> 2][31] == 1'b0, "R11 empty descriptor released", mem[32'h500 >> 2], 0);

    // R10 truncation and R12 base write while busy
    tag = "R10";
    make_desc(32'h520, 32'h8000_0000, 32'h8000, 2100, 1'b1, 1'b1, 32'h600, 5);
    mem[32'h600 >> 2] = 32'h0;
    cfg_write(2'd1, 32'hC000_0002);
    repeat (50) @(negedge clk);
    chk(busy, "R12 engine busy during write", 32'(busy), 1);
    cfg_write(2'd0, 32'h700);
    wait_done("R10");
    cfg_read(2'd2, rv);
    chk(rv == 32'h600, "R12 busy write left current", rv, 32'h600);
    cfg_read(2'd0, rv);
    chk(rv == 32'h100, "R12 busy write left base", rv, 32'h100);
    cfg_write(2'd0, 32'h700);
    cfg_read(2'd2, rv);
    chk(rv == 32'h700, "R12 idle write loads current", rv, 32'h700);
    chk(exp_q.size() == 0, "R13 all bytes delivered", 32'(exp_q.size()), 0);

    finish_run();
  end
endmodule